// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a ring of transmit descriptors held in host memory. Out of reset it is idle. When software raises the start enable, the walker points at the ring base and reads word 0 of the descriptor there through a simple request/acknowledge read port. It then checks the ownership flag. If the DMA owns the descriptor, the walker hands control to the transmit path and waits for that frame to finish. If the DMA does not own it, the walker parks in a suspend state.

A frame-done indication from the transmit path moves the walker to the next descriptor. The next address is the current address plus the descriptor size plus a programmable number of skip words. The descriptor size is 4 words in the basic format and 8 words in the enhanced format. If the end-of-ring flag was set in the descriptor just used, the next address is the ring base instead.

An underflow reported by the transmit path also parks the walker in suspend, and the address is left unchanged. The only way out of suspend is a write to the poll-demand register. That register holds no data: each write strobe becomes a one-cycle wake pulse, and the walker then re-reads the same descriptor.

Top module: `txdesc_ring_walker`

## Requirements
- R1: During and after reset, with start enable low, `eng_state` is 0 (idle) and `rd_req` is low. The state codes are idle=0, fetch=1, transmit=2, suspend=3.
- R2: With start enable raised while idle, the next cycle is fetch, with `cur_addr` equal to `ring_base`. In fetch, `rd_req` stays high with `rd_addr` equal to `cur_addr` until `rd_ack`.
- R3: A fetch acknowledged with bit 31 of the returned word set (DMA owns the descriptor) moves the walker to transmit.
- R4: A frame-done in transmit advances `cur_addr` by (4 + skip) × 4 bytes when the enhanced format is off, and the walker re-enters fetch.
- R5: With the enhanced format on, the advance is (8 + skip) × 4 bytes. The skip can be any value from 0 to 31.
- R6: A skip of 0 places descriptors back to back: the stride is exactly the descriptor size.
- R7: If bit 21 (end of ring) was set in the descriptor's word 0, the next address after frame-done is `ring_base`.
- R8: A fetch acknowledged with bit 31 clear moves the walker to suspend. It stays there, with no read request and an unchanged address, for as long as no poll-demand write occurs.
- R9: A poll-demand write in suspend moves the walker to fetch two cycles after the strobe. It re-reads the same address.
- R10: A poll-demand write has no effect outside suspend. While in transmit, the walker stays in transmit.
- R11: An underflow in transmit moves the walker to suspend and keeps `cur_addr`. Underflow wins over a frame-done in the same cycle.
- R12: Start enable low forces idle on the next cycle from any state. Raising it again restarts at `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_en | input | 1 | Enables the walker; low returns it to idle |
| ring_base | input | AW | Byte address of the first descriptor |
| skip_words | input | 5 | Words skipped between descriptors |
| enh_fmt | input | 1 | 1: 8-word descriptors, 0: 4-word descriptors |
| poll_wr | input | 1 | Poll-demand register write strobe |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Byte address of the word read |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 32 | Descriptor word 0 returned |
| underflow | input | 1 | Underflow reported by the transmit path |
| frame_done | input | 1 | Transmit path finished the current frame |
| eng_state | output | 2 | Walker state code |
| cur_addr | output | AW | Current descriptor byte address |

## Verification
Two events can fall in the same transmit cycle: an underflow from the transmit path and the frame-done that would advance the address. The bench raises both in one cycle while the walker is in transmit. It expects suspend with the address unchanged, which shows that the underflow took precedence and no step was taken. A second pairing puts a poll-demand write in the same window as transmit. There the walker must stay in transmit and ignore the stray wake.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XMIT  = 2'd2,
    ST_SUSP  = 2'd3
  } walk_state_t;

  localparam int OWN_BIT = 31;
  localparam int EOR_BIT = 21;

  typedef struct packed {
    logic own;
    logic eor;
  } desc_flags_t;

  function automatic desc_flags_t decode_word0(input logic [31:0] w);
    desc_flags_t f;
    f.own = w[OWN_BIT];
    f.eor = w[EOR_BIT];
    return f;
  endfunction
endpackage

// File: rtl/txw_poll_pulse.sv
module txw_poll_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic poll_wr,
  output logic wake
);
  logic wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= poll_wr;
  end

  assign wake = wake_q;
endmodule

// File: rtl/txw_addr_step.sv
module txw_addr_step #(
  parameter int AW       = 32,
  parameter int SKIP_W   = 5,
  parameter int BASIC_WD = 4,
  parameter int ENH_WD   = 8
) (
  input  logic [AW-1:0]     cur,
  input  logic [AW-1:0]     base,
  input  logic [SKIP_W-1:0] skip,
  input  logic              enh,
  input  logic              eor,
  output logic [AW-1:0]     nxt
);
  localparam int SUM_W = SKIP_W + 2;
  localparam logic [SUM_W-1:0] BASIC_SZ = SUM_W'(BASIC_WD);
  localparam logic [SUM_W-1:0] ENH_SZ   = SUM_W'(ENH_WD);

  logic [SUM_W-1:0] words;
  logic [AW-1:0]    stride;

  always_comb begin
    words  = (enh ? ENH_SZ : BASIC_SZ) + SUM_W'(skip);
    stride = AW'(words) << 2;
    nxt    = eor ? base : cur + stride;
  end
endmodule

// File: rtl/txdesc_ring_walker.sv
module txdesc_ring_walker
  import txw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SKIP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en,
  input  logic [AW-1:0]     ring_base,
  input  logic [SKIP_W-1:0] skip_words,
  input  logic              enh_fmt,
  input  logic              poll_wr,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [31:0]       rd_data,
  input  logic              underflow,
  input  logic              frame_done,
  output logic [1:0]        eng_state,
  output logic [AW-1:0]     cur_addr
);
  walk_state_t st_q, st_d;
  logic [AW-1:0] addr_q, addr_d, step_addr;
  logic          eor_q;
  logic          addr_en, eor_en, wake;
  desc_flags_t   flags;

  txw_poll_pulse u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .poll_wr(poll_wr),
    .wake  (wake)
  );

  txw_addr_step #(.AW(AW), .SKIP_W(SKIP_W)) u_step (
    .cur  (addr_q),
    .base (ring_base),
    .skip (skip_words),
    .enh  (enh_fmt),
    .eor  (eor_q),
    .nxt  (step_addr)
  );

  assign flags = decode_word0(rd_data);

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    eor_en  = 1'b0;
    if (!start_en) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d    = ST_FETCH;
          addr_d  = ring_base;
          addr_en = 1'b1;
        end
        ST_FETCH: begin
          if (rd_ack) begin
            eor_en = 1'b1;
            st_d   = flags.own ? ST_XMIT : ST_SUSP;
          end
        end
        ST_XMIT: begin
          if (underflow) begin
            st_d = ST_SUSP;
          end else if (frame_done) begin
            st_d    = ST_FETCH;
            addr_d  = step_addr;
            addr_en = 1'b1;
          end
        end
        ST_SUSP: begin
          if (wake) st_d = ST_FETCH;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      eor_q <= 1'b0;
    else if (eor_en) eor_q <= flags.eor;
  end

  assign rd_req    = (st_q == ST_FETCH);
  assign rd_addr   = addr_q;
  assign eng_state = st_q;
  assign cur_addr  = addr_q;
endmodule

// File: rtl/txw_checker.sv
module txw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_en,
  input logic          poll_wr,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic [31:0]   rd_data,
  input logic          underflow,
  input logic [1:0]    eng_state,
  input logic [AW-1:0] cur_addr
);
  // R2: an outstanding read keeps its address
  p_req_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && start_en) |=> (rd_req && $stable(rd_addr)));

  // R3: an owned descriptor leads to transmit
  p_owned_to_xmit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && rd_data[31] && start_en) |=> (eng_state == 2'd2));

  // R8: suspend holds without a poll-demand write
  p_susp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == 2'd3 && start_en && !$past(poll_wr)) |=> (eng_state == 2'd3 && !rd_req));

  // R9: the address is kept across suspend
  p_susp_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == 2'd3) |=> $stable(cur_addr));

  // R11: an underflow in transmit suspends without stepping
  p_uflow_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == 2'd2 && underflow && start_en) |=> (eng_state == 2'd3 && $stable(cur_addr)));

  // R12: start enable low forces idle
  p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !start_en |=> (eng_state == 2'd0));
endmodule

bind txdesc_ring_walker txw_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_en (start_en),
  .poll_wr  (poll_wr),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .rd_ack   (rd_ack),
  .rd_data  (rd_data),
  .underflow(underflow),
  .eng_state(eng_state),
  .cur_addr (cur_addr)
);

// File: tb/test_txdesc_ring_walker.sv
module test_txdesc_ring_walker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h0000_1000;
  // row: [15] enhanced, [14:10] skip, [9:0] expected stride in bytes
  localparam int NROW = 6;
  localparam logic [NROW-1:0][15:0] TBL = {
    {1'b0, 5'd0,  10'd16},
    {1'b1, 5'd0,  10'd32},
    {1'b0, 5'd3,  10'd28},
    {1'b1, 5'd5,  10'd52},
    {1'b0, 5'd31, 10'd140},
    {1'b1, 5'd31, 10'd156}
  };

  logic clk = 1'b0;
  logic rst_n, start_en, enh_fmt, poll_wr, rd_ack, underflow, frame_done;
  logic [4:0] skip_words;
  logic [AW-1:0] ring_base, rd_addr, cur_addr;
  logic [31:0] rd_data;
  logic rd_req;
  logic [1:0] eng_state;
  int checks = 0, fails = 0;
  logic [31:0] exp_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdesc_ring_walker #(.AW(AW)) i_txdesc_ring_walker (
    .clk(clk), .rst_n(rst_n), .start_en(start_en), .ring_base(ring_base),
    .skip_words(skip_words), .enh_fmt(enh_fmt), .poll_wr(poll_wr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .underflow(underflow), .frame_done(frame_done),
    .eng_state(eng_state), .cur_addr(cur_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic respond(input logic own, input logic eor);
    rd_ack  = 1'b1;
    rd_data = 32'h0;
    rd_data[31] = own;
    rd_data[21] = eor;
    step();
    rd_ack  = 1'b0;
    rd_data = 32'h0;
  endtask

  initial begin
    rst_n = 1'b0; start_en = 1'b0; enh_fmt = 1'b0; poll_wr = 1'b0;
    rd_ack = 1'b0; underflow = 1'b0; frame_done = 1'b0;
    skip_words = 5'd0; ring_base = BASE; rd_data = 32'h0;
    repeat (3) step();
    chk("R1 state", 32'(eng_state), 32'd0);
    chk("R1 rd_req", 32'(rd_req), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 idle after reset", 32'(eng_state), 32'd0);
    start_en = 1'b1;
    step();
    chk("R2 fetch", 32'(eng_state), 32'd1);
    chk("R2 rd_addr", rd_addr, BASE);
    step();
    chk("R2 held request", 32'(rd_req), 32'd1);
    respond(1'b1, 1'b0);
    chk("R3 xmit", 32'(eng_state), 32'd2);
    exp_addr = BASE;

    // stride table walk: R4 basic, R5 enhanced, R6 zero skip
    for (int i = 0; i < NROW; i++) begin
      enh_fmt    = TBL[i][15];
      skip_words = TBL[i][14:10];
      frame_done = 1'b1;
      step();
      frame_done = 1'b0;
      exp_addr = exp_addr + 32'(TBL[i][9:0]);
      chk(TBL[i][14:10] == 5'd0 ? "R6 packed stride" : (TBL[i][15] ? "R5 enh stride" : "R4 basic stride"),
          cur_addr, exp_addr);
      chk("R4 refetch", 32'(eng_state), 32'd1);
      respond(1'b1, 1'b0);
    end

    // R10: poll while transmitting is ignored
    poll_wr = 1'b1;
    step();
    poll_wr = 1'b0;
    step();
    step();
    chk("R10 xmit kept", 32'(eng_state), 32'd2);

    // R7: end of ring wraps to base
    enh_fmt = 1'b0; skip_words = 5'd2;
    frame_done = 1'b1; step(); frame_done = 1'b0;
    chk("R4 step before wrap", cur_addr, exp_addr + 32'd24);
    respond(1'b1, 1'b1);
    frame_done = 1'b1; step(); frame_done = 1'b0;
    chk("R7 wrap", cur_addr, BASE);

    // R8: not owned suspends and holds
    respond(1'b0, 1'b0);
    chk("R8 suspend", 32'(eng_state), 32'd3);
    repeat (5) step();
    chk("R8 held", 32'(eng_state), 32'd3);
    chk("R8 no request", 32'(rd_req), 32'd0);

    // R9: poll wakes after two cycles, same address
    poll_wr = 1'b1; step(); poll_wr = 1'b0;
    chk("R9 one cycle later", 32'(eng_state), 32'd3);
    step();
    chk("R9 fetch", 32'(eng_state), 32'd1);
    chk("R9 same addr", rd_addr, BASE);
    respond(1'b1, 1'b0);

    // R11: underflow suspends, keeps address
    underflow = 1'b1; step(); underflow = 1'b0;
    chk("R11 suspend", 32'(eng_state), 32'd3);
    chk("R11 addr", cur_addr, BASE);
    poll_wr = 1'b1; step(); poll_wr = 1'b0; step();
    respond(1'b1, 1'b0);
    underflow = 1'b1; frame_done = 1'b1; step();
    underflow = 1'b0; frame_done = 1'b0;
    chk("R11 priority state", 32'(eng_state), 32'd3);
    chk("R11 priority addr", cur_addr, BASE);

    // R12: stop and restart from base
    poll_wr = 1'b1; step(); poll_wr = 1'b0; step();
    respond(1'b1, 1'b0);
    frame_done = 1'b1; step(); frame_done = 1'b0;
    chk("R12 moved off base", cur_addr, BASE + 32'd24);
    start_en = 1'b0; step();
    chk("R12 idle", 32'(eng_state), 32'd0);
    start_en = 1'b1; step();
    chk("R12 restart", 32'(eng_state), 32'd1);
    chk("R12 restart addr", rd_addr, BASE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule